// File: doc/BRIEF.md
# Pipelined Table-Lookup CRC-32 Engine

This block reduces a byte stream modulo the degree-32 generator 0x04C11DB7. It takes sixteen message bytes per clock and uses no bit-serial shift register. Each beat is cut into four 32-bit lanes. Every lane goes through a byte-sliced lookup that returns the remainder of that word followed by enough zero bytes to reach the end of the beat. A registered pre-XOR stage merges the lanes. The running remainder is advanced by sixteen zero bytes and XORed in. The loop that feeds the remainder back therefore holds one lookup and one two-input XOR.

A message opens with a start beat. On that beat, a separate 32-bit head word carries the first four message bytes, and it is routed into the feedback lookup in place of a prior remainder. The final beat may carry 1 to 16 bytes. The block holds that beat back until the running remainder has settled. It then places the remainder in the four byte positions just above the valid data and sends the beat down the same lane pipeline. The result is the plain polynomial remainder of the message. Appending four zero bytes to a message gives its conventional CRC (zero initial value, no reflection, no output inversion).

Top module: `crc_pipe_engine`

## Requirements
- R1: When `done_o` is high, `crc_o` equals M(x) mod x^32+0x04C11DB7. M is the message read most significant bit first. A message followed by the remainder of itself plus four zero bytes therefore yields 0.
- R2: On a beat with `start_i` high, `head_i[31:24]` is the first message byte and `head_i[7:0]` the fourth. `head_i` is ignored on every other beat.
- R3: A beat with `valid_i` high and `last_i` low carries 16 message bytes in order from `data_i[127:120]` down to `data_i[7:0]`.
- R4: On the beat with `last_i` high, `size_i` = n-1 gives n valid bytes (n from 1 to 16). These bytes sit at the low end, with the final byte in `data_i[7:0]`. Bytes above them do not change the result.
- R5: A message may be a single beat with `start_i` and `last_i` both high, giving 5 to 20 message bytes.
- R6: `done_o` goes high for exactly one cycle. It is high in the cycle that follows the fourth rising edge after the edge that accepts the last beat.
- R7: `crc_o` does not change in the cycle after `done_o`.
- R8: Cycles with `valid_i` low between beats of a message do not change the result.
- R9: After the last beat, `valid_i` stays low until `done_o` is high. The next message's start beat may be presented in the cycle where `done_o` is high.
- R10: During and just after reset, `crc_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat present on `data_i` |
| start_i | input | 1 | Beat opens a message; `head_i` is valid |
| last_i | input | 1 | Beat closes a message; `size_i` is valid |
| size_i | input | 4 | Valid byte count minus one on the last beat |
| head_i | input | 32 | First four message bytes, start beat only |
| data_i | input | 128 | Beat payload |
| crc_o | output | 32 | Remainder of the message |
| done_o | output | 1 | One-cycle strobe, `crc_o` valid |

## Verification
The bench sweeps every last-beat size from 1 to 16 bytes and fills the unused upper bytes with random junk. A wrong byte selector would either shift the remainder to the wrong place or let the junk leak into the result. Sizes 13 to 16 push the remainder partly or fully out of the lane window and into the feedback word. A design that dropped the overflowing bytes would fail only in that range. Single-beat messages check that the head word stands in for the prior remainder, even when the head word must also be aligned into a partial beat. Messages start in the same cycle that the previous `done_o` is high, which catches a stale remainder or a misaligned done strobe. Idle gaps inside a message catch an accumulator that updates when no beat arrives.

// File: rtl/crc_pipe_pkg.sv
package crc_pipe_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] GEN_POLY = 32'h04C11DB7;

  // v * x^nbits mod G, v already reduced
  function automatic logic [CRC_W-1:0] zero_extend_rem(input logic [CRC_W-1:0] v,
                                                       input int unsigned nbits);
    logic [CRC_W-1:0] r;
    r = v;
    for (int unsigned i = 0; i < nbits; i++) begin
      r = {r[CRC_W-2:0], 1'b0} ^ (r[CRC_W-1] ? GEN_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_zlut.sv
// Remainder of a 32-bit word followed by ZBYTES zero bytes, one table per byte.
module crc_zlut
  import crc_pipe_pkg::*;
#(
  parameter int unsigned ZBYTES = 4
) (
  input  logic [CRC_W-1:0] word_i,
  output logic [CRC_W-1:0] rem_o
);
  localparam int unsigned NSLICE = CRC_W / 8;

  logic [CRC_W-1:0] slice_rem [NSLICE];

  for (genvar p = 0; p < NSLICE; p++) begin : g_slice
    assign slice_rem[p] = zero_extend_rem({{(CRC_W-8){1'b0}}, word_i[8*p +: 8]},
                                          8 * (p + ZBYTES));
  end

  always_comb begin
    rem_o = '0;
    for (int p = 0; p < NSLICE; p++) rem_o ^= slice_rem[p];
  end
endmodule

// File: rtl/crc_align.sv
// Last-beat byte steering: data low, prior remainder just above, zero beyond.
module crc_align
  import crc_pipe_pkg::*;
#(
  parameter int unsigned NBYTES = 16,
  localparam int unsigned SZW = $clog2(NBYTES)
) (
  input  logic [CRC_W-1:0]    rem_i,
  input  logic [8*NBYTES-1:0] data_i,
  input  logic [SZW-1:0]      size_i,
  output logic [8*NBYTES-1:0] win_o,
  output logic [CRC_W-1:0]    fw_o
);
  localparam int unsigned RB = CRC_W / 8;
  localparam int unsigned VB = NBYTES + RB;

  logic [8*VB-1:0] data_ext;
  logic [8*VB-1:0] v;
  int              cnt;

  assign data_ext = {{CRC_W{1'b0}}, data_i};
  assign cnt      = int'(size_i) + 1;

  always_comb begin
    v = '0;
    for (int j = 0; j < VB; j++) begin
      if (j < cnt)           v[8*j +: 8] = data_ext[8*j +: 8];
      else if (j < cnt + RB) v[8*j +: 8] = rem_i[8*((j - cnt) % RB) +: 8];
    end
  end

  assign win_o = v[8*NBYTES-1:0];
  assign fw_o  = v[8*VB-1 -: CRC_W];
endmodule

// File: rtl/crc_pipe_engine.sv
module crc_pipe_engine
  import crc_pipe_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned NBYTES = 4 * LANES,
  localparam int unsigned DATA_W = 8 * NBYTES,
  localparam int unsigned SZW    = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic              last_i,
  input  logic [SZW-1:0]    size_i,
  input  logic [CRC_W-1:0]  head_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  // last-beat hold
  logic [DATA_W-1:0] hold_data;
  logic [SZW-1:0]    hold_size;
  logic [CRC_W-1:0]  hold_head;
  logic              hold_start;
  logic [1:0]        pend_q;
  logic              inject;

  // pipeline
  logic [CRC_W-1:0]  acc_q;
  logic [DATA_W-1:0] in_win, al_win;
  logic [CRC_W-1:0]  in_fw, al_fw, al_rem;
  logic              in_valid, in_use_fw;
  logic [CRC_W-1:0]  lane_word [LANES];
  logic [CRC_W-1:0]  lane_rem  [LANES];
  logic [CRC_W-1:0]  s1_lane   [LANES];
  logic [CRC_W-1:0]  s1_fw, s2_fw, s2_pre, pre_x, fb_src, fb_rem;
  logic              s1_valid, s1_use_fw, s1_final;
  logic              s2_valid, s2_use_fw, s2_final;
  logic              done_q;

  assign inject = pend_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      hold_data  <= '0;
      hold_size  <= '0;
      hold_head  <= '0;
      hold_start <= 1'b0;
    end else begin
      pend_q <= {pend_q[0], valid_i & last_i};
      if (valid_i && last_i) begin
        hold_data  <= data_i;
        hold_size  <= size_i;
        hold_head  <= head_i;
        hold_start <= start_i;
      end
    end
  end

  // single-beat message: head word stands in for the prior remainder
  assign al_rem = hold_start ? hold_head : acc_q;

  crc_align #(.NBYTES(NBYTES)) u_align (
    .rem_i  (al_rem),
    .data_i (hold_data),
    .size_i (hold_size),
    .win_o  (al_win),
    .fw_o   (al_fw)
  );

  assign in_win    = inject ? al_win : data_i;
  assign in_fw     = inject ? al_fw  : head_i;
  assign in_valid  = inject | (valid_i & ~last_i);
  assign in_use_fw = inject | (valid_i & ~last_i & start_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_word[k] = in_win[DATA_W-1-CRC_W*k -: CRC_W];
    if (k == LANES - 1) begin : g_pass
      assign lane_rem[k] = lane_word[k];
    end else begin : g_lut
      crc_zlut #(.ZBYTES(4 * (LANES - 1 - k))) u_lut (
        .word_i (lane_word[k]),
        .rem_o  (lane_rem[k])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LANES; k++) s1_lane[k] <= '0;
      s1_fw     <= '0;
      s1_valid  <= 1'b0;
      s1_use_fw <= 1'b0;
      s1_final  <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_use_fw <= in_use_fw;
      s1_final  <= inject;
      if (in_valid) begin
        for (int k = 0; k < LANES; k++) s1_lane[k] <= lane_rem[k];
        s1_fw <= in_fw;
      end
    end
  end

  always_comb begin
    pre_x = '0;
    for (int k = 0; k < LANES; k++) pre_x ^= s1_lane[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_pre    <= '0;
      s2_fw     <= '0;
      s2_valid  <= 1'b0;
      s2_use_fw <= 1'b0;
      s2_final  <= 1'b0;
    end else begin
      s2_valid  <= s1_valid;
      s2_use_fw <= s1_use_fw;
      s2_final  <= s1_final & s1_valid;
      if (s1_valid) begin
        s2_pre <= pre_x;
        s2_fw  <= s1_fw;
      end
    end
  end

  assign fb_src = s2_use_fw ? s2_fw : acc_q;

  crc_zlut #(.ZBYTES(NBYTES)) u_fb (
    .word_i (fb_src),
    .rem_o  (fb_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= s2_valid & s2_final;
      if (s2_valid) acc_q <= fb_rem ^ s2_pre;
    end
  end

  assign crc_o  = acc_q;
  assign done_o = done_q;

  // R6
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && last_i, 5));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(crc_o));
  // R8
  acc_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_valid |=> $stable(acc_q));
  // R9
  no_beat_in_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|pend_q) || (s1_valid && s1_final) || s2_final) |-> !valid_i);
endmodule

// File: tb/tb_crc_pipe_engine.sv
`timescale 1ns/1ps
module tb_crc_pipe_engine;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0, start_i = 1'b0, last_i = 1'b0;
  logic [3:0]   size_i = '0;
  logic [31:0]  head_i = '0;
  logic [127:0] data_i = '0;
  logic [31:0]  crc_o;
  logic         done_o;

  int checks = 0, fails = 0, cyc = 0;
  int          exp_edge [$];
  logic [31:0] exp_crc  [$];
  string       exp_tag  [$];
  int          hold_edge = -1;
  logic [31:0] hold_val = '0;

  always #5 clk_i = ~clk_i;

  crc_pipe_engine dut (
    .clk_i, .rst_ni, .valid_i, .start_i, .last_i, .size_i,
    .head_i, .data_i, .crc_o, .done_o
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] ref_rem(input logic [7:0] m[$]);
    logic [31:0] r = '0;
    foreach (m[i]) begin
      for (int b = 7; b >= 0; b--) begin
        logic top = r[31];
        r = {r[30:0], m[i][b]};
        if (top) r = r ^ POLY;
      end
    end
    return r;
  endfunction

  // per-cycle comparison against the expectation queue
  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic exp_done;
      exp_done = (exp_edge.size() > 0) && (exp_edge[0] == cyc);
      checks++;
      if (done_o !== exp_done) begin
        fails++;
        $display("FAIL R6: done_o=%b expected %b at cycle %0d", done_o, exp_done, cyc);
      end
      if (exp_done) begin
        checks++;
        if (crc_o !== exp_crc[0]) begin
          fails++;
          $display("FAIL %s: crc_o=%h expected %h", exp_tag[0], crc_o, exp_crc[0]);
        end
        hold_edge = cyc + 1;
        hold_val  = exp_crc[0];
        void'(exp_edge.pop_front());
        void'(exp_crc.pop_front());
        void'(exp_tag.pop_front());
      end else if (cyc == hold_edge) begin
        checks++;
        if (crc_o !== hold_val) begin
          fails++;
          $display("FAIL R7: crc_o=%h expected %h after done", crc_o, hold_val);
        end
      end
    end
  end

  task automatic send_msg(input logic [7:0] m[$], input logic [31:0] expv,
                          input int gap, input bit junk, input string tag);
    int rest  = m.size() - 4;
    int nb    = (rest + 15) / 16;
    int lastn = rest - 16 * (nb - 1);
    int tgt   = 0;
    logic [31:0] hd = {m[0], m[1], m[2], m[3]};
    for (int b = 0; b < nb; b++) begin
      logic [127:0] d;
      @(negedge clk_i);
      d = '0;
      if (b == nb - 1) begin
        if (junk) d = {$urandom, $urandom, $urandom, $urandom};
        for (int i = 0; i < lastn; i++) d[8*(lastn-1-i) +: 8] = m[4+16*b+i];
      end else begin
        for (int i = 0; i < 16; i++) d[127-8*i -: 8] = m[4+16*b+i];
      end
      data_i  = d;
      valid_i = 1'b1;
      start_i = (b == 0);
      last_i  = (b == nb - 1);
      head_i  = (b == 0) ? hd : $urandom;
      size_i  = (b == nb - 1) ? 4'(lastn - 1) : 4'($urandom);
      if (b == nb - 1) begin
        tgt = cyc + 5;
        exp_edge.push_back(tgt);
        exp_crc.push_back(expv);
        exp_tag.push_back(tag);
      end else if (gap > 0) begin
        @(negedge clk_i);
        valid_i = 1'b0;
        repeat (gap - 1) @(negedge clk_i);
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    start_i = 1'b0;
    last_i  = 1'b0;
    while (cyc < tgt - 1) @(negedge clk_i);
  endtask

  task automatic rand_msg(output logic [7:0] m[$], input int len);
    m.delete();
    for (int i = 0; i < len; i++) m.push_back(8'($urandom));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] m[$];
    logic [7:0] p[$];
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    checks++;
    if (crc_o !== 32'h0 || done_o !== 1'b0) begin
      fails++;
      $display("FAIL R10: crc_o=%h done_o=%b expected 0 0 in reset", crc_o, done_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (crc_o !== 32'h0 || done_o !== 1'b0) begin
      fails++;
      $display("FAIL R10: crc_o=%h done_o=%b expected 0 0 after reset", crc_o, done_o);
    end

    // R5 single full beat, then single one-byte beat
    rand_msg(m, 20); send_msg(m, ref_rem(m), 0, 1'b0, "R5");
    rand_msg(m, 5);  send_msg(m, ref_rem(m), 0, 1'b1, "R5");
    // R2 head word with all ones
    rand_msg(m, 36); m[0] = 8'hFF; m[1] = 8'hFF; m[2] = 8'hFF; m[3] = 8'hFF;
    send_msg(m, ref_rem(m), 0, 1'b0, "R2");
    // R4 every last-beat size with junk above the valid bytes
    for (int s = 1; s <= 16; s++) begin
      rand_msg(m, 4 + 16 + s); send_msg(m, ref_rem(m), 0, 1'b1, "R4");
    end
    // R5 single beat of every size
    for (int s = 1; s <= 16; s++) begin
      rand_msg(m, 4 + s); send_msg(m, ref_rem(m), 0, 1'b1, "R5");
    end
    // R3 full beats only
    rand_msg(m, 4 + 64); send_msg(m, ref_rem(m), 0, 1'b0, "R3");
    // R8 idle gaps inside a message
    rand_msg(m, 4 + 48 + 13); send_msg(m, ref_rem(m), 3, 1'b1, "R8");
    rand_msg(m, 4 + 32 + 7);  send_msg(m, ref_rem(m), 1, 1'b0, "R8");
    // R1 message followed by its own remainder leaves zero
    rand_msg(p, 37);
    m = p; for (int i = 0; i < 4; i++) m.push_back(8'h00);
    r = ref_rem(m);
    m = p; m.push_back(r[31:24]); m.push_back(r[23:16]); m.push_back(r[15:8]); m.push_back(r[7:0]);
    send_msg(m, 32'h0, 0, 1'b1, "R1");
    // R1 all-zero payload after a nonzero head
    m.delete(); m.push_back(8'h80); for (int i = 0; i < 19; i++) m.push_back(8'h00);
    send_msg(m, ref_rem(m), 0, 1'b0, "R1");
    // R9 next message starts in the done cycle (every send above does this)
    rand_msg(m, 4 + 16 + 16 + 2); send_msg(m, ref_rem(m), 0, 1'b1, "R9");
    repeat (4) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule